// File: doc/BRIEF.md
# Two-Wire Master Register and Interrupt Front End

This block is the software-facing register file that sits in front of a two-wire (I2C-style) master sequencer. A processor reaches it through a plain 32-bit word bus: byte address, write strobe, write data and a combinational read-data return. It holds the bus clock settings for the standard/fast and high-speed modes and a general configuration word. It also holds a slave address, a 64-bit data window split over two words, a status word, a mask word and a busy indication. All of these are presented to the sequencer as plain control pins.

Software loads the address, the outgoing bytes and the configuration. It then writes the command word, which launches the sequencer with a one-cycle start pulse while the busy flag rises. When the sequencer reports completion with a one-cycle done pulse, busy clears. In the same clock edge the done bit and the sequencer's error flags are merged into the status word. If that completion carried a read phase, the received bytes replace the data window. Status bits are cleared by writing ones, and the interrupt pin follows any status bit whose mask bit is set. Done is recorded on every completion, so software can mask in only done and still read all the error flags. The start/done pair is a plain pulse protocol: the sequencer cannot push back, and the block ignores command writes until the running command finishes.

Word offsets, as byte addresses: 0x00 standard clock, 0x04 high-speed clock, 0x08 configuration, 0x0C command, 0x10 slave address, 0x14 data low, 0x18 data high, 0x1C status, 0x20 mask, 0x24 busy. Writes whose address has either of its two low bits set are dropped.

Top module: `twi_regfile`

## Requirements
- R1: After reset both clock words read 0x301F, configuration reads 0x3302, status, mask and busy read 0, and irq and seq_start are low.
- R2: A clock word keeps only bits 15:12 (filter) and 9:0 (divider) of a write; every other bit reads 0, and the stored value appears on its seq_clk pin.
- R3: The configuration word keeps bits 15:4, 1 and 0 of a write (arbitration filter 15:12, NAK setting 11:8, ten-bit address 7, master code 6:4, arbitration enable 1, high-speed 0); bits 3:2 and 31:16 read 0, and the value drives seq_cfg.
- R4: A command write while idle stores the value masked to bits 9:8, 6:4 and 2:0, drives it on seq_cmd, makes busy read 1, and pulses seq_start high for exactly the one cycle after the write edge.
- R5: A command write while busy reads 1 produces no start pulse and leaves the command readback unchanged.
- R6: On a seq_done pulse, busy reads 0 after that edge, and the status word gains bit 0 (done) plus seq_flags[3:0] at bits 4:1 (bit 1 lost arbitration, bit 2 no response, bit 3 data collision, bit 4 bus busy).
- R7: Writing the status word clears exactly the bits written as one; a completion in the same cycle sets its bits even if the same write clears them.
- R8: irq is high exactly when some status bit and its mask bit (same position, bits 4:0) are both one.
- R9: The data words take seq_rdata (low word bits 31:0, high word bits 63:32) only on a seq_done that has seq_rd_valid high; a completion without it leaves software-written data unchanged.
- R10: Slave address (bits 9:0) and the data words drive seq_slave and seq_wdata (high word on bits 63:32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| seq_start | output | 1 | One-cycle launch pulse to the sequencer |
| seq_cmd | output | 16 | Stored command word |
| seq_slave | output | SLV_W | Slave address |
| seq_wdata | output | 64 | Outgoing data window |
| seq_cfg | output | 16 | Configuration word |
| seq_clk_std | output | 16 | Standard/fast clock word |
| seq_clk_hs | output | 16 | High-speed clock word |
| seq_done | input | 1 | Completion pulse from the sequencer |
| seq_flags | input | 4 | Error flags valid with seq_done |
| seq_rd_valid | input | 1 | Completion carried a read phase |
| seq_rdata | input | 64 | Received bytes valid with seq_done |

## Verification
On every cycle the assertions check that the start pulse lasts one cycle and only occurs while busy, that a command write during busy cannot start anything, and that a completion drops busy and records done on the next edge. They also check that irq stays low whenever no unmasked status bit is set, and that the data low word cannot move without a read completion or a bus write to it. The field masks, reset values, the write-one-to-clear arithmetic, the set-beats-clear collision and the exact flag-to-bit mapping need the bench's scenarios, which read back every word after chosen writes and completions.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;
  localparam int unsigned NUM_WORDS = 10;
  localparam int unsigned STS_W     = 5;
  localparam int unsigned FLAG_W    = 4;

  localparam int unsigned IDX_CLK_STD = 0;
  localparam int unsigned IDX_CLK_HS  = 1;
  localparam int unsigned IDX_CFG     = 2;
  localparam int unsigned IDX_CMD     = 3;
  localparam int unsigned IDX_SLV     = 4;
  localparam int unsigned IDX_DLO     = 5;
  localparam int unsigned IDX_DHI     = 6;
  localparam int unsigned IDX_STS     = 7;
  localparam int unsigned IDX_MSK     = 8;
  localparam int unsigned IDX_BSY     = 9;

  localparam logic [15:0] CLK_KEEP = 16'hF3FF;
  localparam logic [15:0] CLK_INIT = 16'h301F;
  localparam logic [15:0] CFG_KEEP = 16'hFFF3;
  localparam logic [15:0] CFG_INIT = 16'h3302;
  localparam logic [15:0] CMD_KEEP = 16'h0377;
endpackage

// File: rtl/twi_field_reg.sv
module twi_field_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] KEEP = '1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= INIT;
    else if (we) q <= wdata & KEEP;
  end
endmodule

// File: rtl/twi_cmd_ctrl.sv
module twi_cmd_ctrl #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_we,
  input  logic [W-1:0] cmd_wdata,
  input  logic         done,
  output logic         busy,
  output logic         start,
  output logic [W-1:0] cmd_q
);
  logic accept;
  assign accept = cmd_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      start <= 1'b0;
      cmd_q <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        busy  <= 1'b1;
        cmd_q <= cmd_wdata & KEEP;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twi_irq_ctrl.sv
module twi_irq_ctrl #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sts_we,
  input  logic         msk_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] sts,
  output logic [N-1:0] msk,
  output logic         irq
);
  logic [N-1:0] clr_vec;
  assign clr_vec = sts_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      msk <= '0;
    end else begin
      sts <= (sts & ~clr_vec) | set_vec;
      if (msk_we) msk <= wdata;
    end
  end

  assign irq = |(sts & msk);
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
  import twi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SLV_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              seq_start,
  output logic [15:0]       seq_cmd,
  output logic [SLV_W-1:0]  seq_slave,
  output logic [63:0]       seq_wdata,
  output logic [15:0]       seq_cfg,
  output logic [15:0]       seq_clk_std,
  output logic [15:0]       seq_clk_hs,
  input  logic              seq_done,
  input  logic [3:0]        seq_flags,
  input  logic              seq_rd_valid,
  input  logic [63:0]       seq_rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     widx;
  logic                 aligned;
  logic [NUM_WORDS-1:0] wsel;
  logic [15:0]          clk_q [2];
  logic                 busy;
  logic [STS_W-1:0]     sts;
  logic [STS_W-1:0]     msk;
  logic [STS_W-1:0]     set_vec;
  logic [31:0]          data_lo;
  logic [31:0]          data_hi;
  logic                 rd_load;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign wsel[i] = bus_we && aligned && (widx == IDX_W'(i));
  end

  for (genvar c = 0; c < 2; c++) begin : g_clk
    twi_field_reg #(.W(16), .KEEP(CLK_KEEP), .INIT(CLK_INIT)) u_clk (
      .clk(clk), .rst_n(rst_n), .we(wsel[IDX_CLK_STD + c]),
      .wdata(bus_wdata[15:0]), .q(clk_q[c])
    );
  end

  twi_field_reg #(.W(16), .KEEP(CFG_KEEP), .INIT(CFG_INIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wsel[IDX_CFG]),
    .wdata(bus_wdata[15:0]), .q(seq_cfg)
  );

  twi_field_reg #(.W(SLV_W), .KEEP('1), .INIT('0)) u_slv (
    .clk(clk), .rst_n(rst_n), .we(wsel[IDX_SLV]),
    .wdata(bus_wdata[SLV_W-1:0]), .q(seq_slave)
  );

  twi_cmd_ctrl #(.W(16), .KEEP(CMD_KEEP)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(wsel[IDX_CMD]),
    .cmd_wdata(bus_wdata[15:0]), .done(seq_done),
    .busy(busy), .start(seq_start), .cmd_q(seq_cmd)
  );

  assign set_vec = seq_done ? {seq_flags, 1'b1} : '0;

  twi_irq_ctrl #(.N(STS_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .sts_we(wsel[IDX_STS]), .msk_we(wsel[IDX_MSK]),
    .wdata(bus_wdata[STS_W-1:0]), .set_vec(set_vec),
    .sts(sts), .msk(msk), .irq(irq)
  );

  assign rd_load = seq_done && seq_rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_lo <= '0;
      data_hi <= '0;
    end else if (rd_load) begin
      data_lo <= seq_rdata[31:0];
      data_hi <= seq_rdata[63:32];
    end else begin
      if (wsel[IDX_DLO]) data_lo <= bus_wdata;
      if (wsel[IDX_DHI]) data_hi <= bus_wdata;
    end
  end

  assign seq_wdata   = {data_hi, data_lo};
  assign seq_clk_std = clk_q[0];
  assign seq_clk_hs  = clk_q[1];

  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_W'(IDX_CLK_STD): bus_rdata[15:0]      = clk_q[0];
      IDX_W'(IDX_CLK_HS):  bus_rdata[15:0]      = clk_q[1];
      IDX_W'(IDX_CFG):     bus_rdata[15:0]      = seq_cfg;
      IDX_W'(IDX_CMD):     bus_rdata[15:0]      = seq_cmd;
      IDX_W'(IDX_SLV):     bus_rdata[SLV_W-1:0] = seq_slave;
      IDX_W'(IDX_DLO):     bus_rdata            = data_lo;
      IDX_W'(IDX_DHI):     bus_rdata            = data_hi;
      IDX_W'(IDX_STS):     bus_rdata[STS_W-1:0] = sts;
      IDX_W'(IDX_MSK):     bus_rdata[STS_W-1:0] = msk;
      IDX_W'(IDX_BSY):     bus_rdata[0]         = busy;
      default:             bus_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/twi_regfile_chk.sv
module twi_regfile_chk
  import twi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              seq_done,
  input logic              seq_rd_valid,
  input logic              seq_start,
  input logic              busy,
  input logic [STS_W-1:0]  sts,
  input logic [STS_W-1:0]  msk,
  input logic              irq,
  input logic [31:0]       data_lo
);
  logic cmd_wr;
  logic dlo_wr;
  assign cmd_wr = bus_we && (bus_addr == ADDR_W'(IDX_CMD * 4));
  assign dlo_wr = bus_we && (bus_addr == ADDR_W'(IDX_DLO * 4));

  p_start_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy);
  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> !seq_start);
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seq_done && !cmd_wr) |=> !busy);
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> sts[0]);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & msk) == '0) |-> !irq);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(seq_done && seq_rd_valid) && !dlo_wr) |=> $stable(data_lo));
endmodule

bind twi_regfile twi_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .seq_done(seq_done), .seq_rd_valid(seq_rd_valid), .seq_start(seq_start),
  .busy(busy), .sts(sts), .msk(msk), .irq(irq), .data_lo(data_lo)
);

// File: tb/twi_regfile_tb.sv
module twi_regfile_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SLV_W  = 10;

  localparam logic [7:0] A_CLK_STD = 8'h00, A_CLK_HS = 8'h04, A_CFG = 8'h08,
                         A_CMD = 8'h0C, A_SLV = 8'h10, A_DLO = 8'h14,
                         A_DHI = 8'h18, A_STS = 8'h1C, A_MSK = 8'h20,
                         A_BSY = 8'h24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq;
  logic              seq_start;
  logic [15:0]       seq_cmd;
  logic [SLV_W-1:0]  seq_slave;
  logic [63:0]       seq_wdata;
  logic [15:0]       seq_cfg, seq_clk_std, seq_clk_hs;
  logic              seq_done = 1'b0;
  logic [3:0]        seq_flags = '0;
  logic              seq_rd_valid = 1'b0;
  logic [63:0]       seq_rdata = '0;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  twi_regfile #(.ADDR_W(ADDR_W), .SLV_W(SLV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .seq_start(seq_start), .seq_cmd(seq_cmd), .seq_slave(seq_slave),
    .seq_wdata(seq_wdata), .seq_cfg(seq_cfg), .seq_clk_std(seq_clk_std),
    .seq_clk_hs(seq_clk_hs), .seq_done(seq_done), .seq_flags(seq_flags),
    .seq_rd_valid(seq_rd_valid), .seq_rdata(seq_rdata)
  );

  typedef struct {
    logic [31:0] exp;
    logic [7:0]  addr;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;

  always begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      nchk++;
      if (bus_rdata !== it.exp) begin
        nerr++;
        $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h",
                 it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    #1;
    it.exp = e; it.addr = a; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic pin(input logic [63:0] act, input logic [63:0] e, input string tag);
    nchk++;
    if (act !== e) begin
      nerr++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, e);
    end
  endtask

  task automatic finish_seq(input logic [3:0] fl, input logic rv, input logic [63:0] rdat);
    @(negedge clk);
    seq_done = 1'b1; seq_flags = fl; seq_rd_valid = rv; seq_rdata = rdat;
    @(negedge clk);
    seq_done = 1'b0; seq_flags = '0; seq_rd_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CLK_STD, 32'h301F, "R1 clk std");
    rd(A_CLK_HS,  32'h301F, "R1 clk hs");
    rd(A_CFG,     32'h3302, "R1 cfg");
    rd(A_STS,     32'h0,    "R1 status");
    rd(A_MSK,     32'h0,    "R1 mask");
    rd(A_BSY,     32'h0,    "R1 busy");
    pin(irq, 0, "R1 irq");
    pin(seq_start, 0, "R1 start");

    // R2 clock words
    wr(A_CLK_STD, 32'hFFFF_FFFF);
    rd(A_CLK_STD, 32'hF3FF, "R2 clk std mask");
    wr(A_CLK_HS, 32'h0001_2345);
    rd(A_CLK_HS, 32'h2345, "R2 clk hs");
    pin(seq_clk_hs, 16'h2345, "R2 clk hs pin");
    pin(seq_clk_std, 16'hF3FF, "R2 clk std pin");

    // R3 configuration
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, 32'hFFF3, "R3 cfg mask");
    pin(seq_cfg, 16'hFFF3, "R3 cfg pin");
    wr(A_CFG, 32'h0000_008C);
    rd(A_CFG, 32'h0080, "R3 cfg reserved bits");

    // R10 outgoing data and address
    wr(A_SLV, 32'h0000_FFFF);
    rd(A_SLV, 32'h03FF, "R10 slave");
    wr(A_DLO, 32'hA1B2_C3D4);
    wr(A_DHI, 32'h1122_3344);
    pin(seq_wdata, 64'h1122_3344_A1B2_C3D4, "R10 wdata pin");
    pin(seq_slave, 10'h3FF, "R10 slave pin");

    // R4 launch
    wr(A_MSK, 32'h1);
    wr(A_CMD, 32'hFFFF_0275);
    pin(seq_start, 1, "R4 start pulse");
    pin(seq_cmd, 16'h0275, "R4 cmd pin");
    @(negedge clk);
    pin(seq_start, 0, "R4 start one cycle");
    rd(A_BSY, 32'h1, "R4 busy");

    // R5 ignored while busy
    wr(A_CMD, 32'h0100);
    pin(seq_start, 0, "R5 no start");
    rd(A_CMD, 32'h0275, "R5 cmd unchanged");

    // R6 / R9 / R8 completion with read data, no-response flag
    finish_seq(4'b0010, 1'b1, 64'hCAFE_F00D_0BAD_BEEF);
    rd(A_BSY, 32'h0, "R6 busy cleared");
    rd(A_STS, 32'h5, "R6 status done+noresp");
    pin(irq, 1, "R8 irq done masked in");
    rd(A_DLO, 32'h0BAD_BEEF, "R9 data lo loaded");
    rd(A_DHI, 32'hCAFE_F00D, "R9 data hi loaded");

    // R7 write-one-to-clear
    wr(A_STS, 32'h4);
    rd(A_STS, 32'h1, "R7 clear bit2");
    pin(irq, 1, "R8 irq still done");
    wr(A_STS, 32'h1);
    rd(A_STS, 32'h0, "R7 clear done");
    pin(irq, 0, "R8 irq low");

    // R8 masked out / R9 no read phase
    wr(A_MSK, 32'h4);
    wr(A_DLO, 32'h55AA_55AA);
    wr(A_CMD, 32'h0011);
    pin(seq_start, 1, "R4 second start");
    finish_seq(4'b1000, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_STS, 32'h11, "R6 status done+busbus");
    pin(irq, 0, "R8 irq masked off");
    rd(A_DLO, 32'h55AA_55AA, "R9 data kept");
    wr(A_MSK, 32'h10);
    pin(irq, 1, "R8 irq on mask change");

    // R7 completion beats same-cycle clear
    wr(A_STS, 32'h1F);
    wr(A_CMD, 32'h0022);
    @(negedge clk);
    bus_addr = A_STS; bus_wdata = 32'h3; bus_we = 1'b1;
    seq_done = 1'b1; seq_flags = 4'b0001; seq_rd_valid = 1'b0;
    @(negedge clk);
    bus_we = 1'b0; seq_done = 1'b0; seq_flags = '0;
    rd(A_STS, 32'h3, "R7 set wins over clear");
    rd(A_BSY, 32'h0, "R6 busy after collision");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule